// File: doc/BRIEF.md
# Indexed Multi-Channel Edge Detector

The block watches a wide input bus, 256 bits by default, and reports edges on each bit separately. Each bit has its own 2-bit edge code. The code selects rising edges, falling edges, or both edges (toggle). Each bit also has a suppress bit that silences that bit's detector. An edge is found by comparing the current input with a copy of the input registered in the previous cycle. The block drives a per-cycle event vector and a registered any-event flag.

Software reaches the per-bit settings through a selected-channel scheme. It first writes a channel number into the selector register. A following write to the code register or to the suppress register then lands on the channel the selector holds. The same register port reads back the selector and every stored setting. Codes read back 16 channels per 32-bit word, and suppress bits read back 32 channels per word.

Top module: `edge_scan_top`

## Requirements
- R1: After reset the selector reads 0 at read address 0. Every code word at read addresses 16 to 31 reads 0, which means all channels detect rising edges. Every suppress word at read addresses 32 to 39 reads 0.
- R2: A write to address 0 loads wr_data[7:0] into the selector. A write to address 1 stores wr_data[1:0] as the code of the selected channel. Channel n's code reads back in word 16 + n/16, at bits [2*(n%16)+1 : 2*(n%16)].
- R3: A write to address 2 stores wr_data[0] as the suppress bit of the selected channel. Channel n's suppress bit reads back in word 32 + n/32, at bit n%32.
- R4: A code write with wr_data[1:0] = 3 is ignored, and the selected channel keeps its stored code.
- R5: A channel with code 0 sets its event bit in a cycle where its input is 1 and its previous-cycle input was 0.
- R6: A channel with code 1 sets its event bit in a cycle where its input is 0 and its previous-cycle input was 1.
- R7: A channel with code 2 sets its event bit in any cycle where its input differs from its previous-cycle input.
- R8: A channel whose suppress bit is 1 never sets its event bit.
- R9: any_o is 1 in a cycle exactly when at least one event bit was set in the cycle before.
- R10: No event bit is set while det_en is 0. No event bit is set in the first cycle after reset with det_en at 1, nor in the first cycle after det_en rises. The previous-cycle copy of the input is taken only while det_en is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address: 0 selector, 1 code, 2 suppress |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| det_en | input | 1 | Detection enable |
| din | input | 256 | Watched input bus |
| event_o | output | 256 | Per-channel edge events for the current cycle |
| any_o | output | 1 | OR of the previous cycle's event bits |

## Verification
The hardest case to reach is a mixed population: every edge code and suppressed channels sitting side by side, while the bus changes in many lanes at once. A bug that swaps codes between neighbouring channels, or misplaces a packed field, only shows up when adjacent lanes disagree. The bench therefore programs all 256 channels through the selector sequence. It uses a rotating code pattern and a sparse suppress pattern, and it also attempts reserved-code writes. It then drives random full-width bus values and directed all-toggle patterns, and it toggles det_en during the run. This covers the first-cycle and disabled-cycle rules with edges present on the bus.

// File: rtl/edge_scan_pkg.sv
package edge_scan_pkg;

  // Edge codes held per channel
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_RSVD = 2'd3
  } edge_kind_e;

  // Register map (write side and read side)
  localparam int REG_SEL   = 0;
  localparam int REG_CODE  = 1;
  localparam int REG_SUPP  = 2;
  localparam int CODE_BASE = 16;
  localparam int SUPP_BASE = 32;

  function automatic logic code_legal(input logic [1:0] code);
    return code != EDGE_RSVD;
  endfunction

  function automatic logic edge_hit(input logic [1:0] code, input logic prev, input logic cur);
    logic hit;
    case (code)
      EDGE_RISE: hit = cur & ~prev;
      EDGE_FALL: hit = prev & ~cur;
      EDGE_BOTH: hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
  import edge_scan_pkg::*;
#(
  parameter int NUM_CH = 256,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CODE_PER_WORD = WORD_W / 2,
  localparam int CODE_WORDS = NUM_CH / CODE_PER_WORD,
  localparam int SUPP_WORDS = NUM_CH / WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [WORD_W-1:0]   rd_data,
  output logic [2*NUM_CH-1:0] code_vec,
  output logic [NUM_CH-1:0]   supp_vec,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [1:0]          sel_code
);

  logic [IDX_W-1:0]    sel_q;
  logic [2*NUM_CH-1:0] code_q;
  logic [NUM_CH-1:0]   supp_q;
  logic                unused_wr_hi;

  assign unused_wr_hi = ^wr_data[WORD_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      code_q <= '0;
      supp_q <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) == REG_SEL) begin
        sel_q <= wr_data[IDX_W-1:0];
      end else if (int'(wr_addr) == REG_CODE) begin
        if (code_legal(wr_data[1:0])) code_q[{sel_q, 1'b0} +: 2] <= wr_data[1:0];
      end else if (int'(wr_addr) == REG_SUPP) begin
        supp_q[sel_q] <= wr_data[0];
      end
    end
  end

  assign code_vec = code_q;
  assign supp_vec = supp_q;
  assign sel_idx  = sel_q;
  assign sel_code = code_q[{sel_q, 1'b0} +: 2];

  // Packed readback of selector, code words and suppress words
  always_comb begin
    int a;
    a = int'(rd_addr);
    rd_data = '0;
    if (a == REG_SEL) begin
      rd_data[IDX_W-1:0] = sel_q;
    end else if (a >= CODE_BASE && a < CODE_BASE + CODE_WORDS) begin
      rd_data = code_q[(a - CODE_BASE) * WORD_W +: WORD_W];
    end else if (a >= SUPP_BASE && a < SUPP_BASE + SUPP_WORDS) begin
      rd_data = supp_q[(a - SUPP_BASE) * WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/edge_lane.sv
module edge_lane
  import edge_scan_pkg::*;
(
  input  logic       cur,
  input  logic       prev,
  input  logic [1:0] code,
  input  logic       supp,
  input  logic       live,
  output logic       hit
);

  assign hit = live & ~supp & edge_hit(code, prev, cur);

endmodule

// File: rtl/edge_event_core.sv
module edge_event_core #(
  parameter int NUM_CH = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                det_en,
  input  logic [NUM_CH-1:0]   din,
  input  logic [2*NUM_CH-1:0] code_vec,
  input  logic [NUM_CH-1:0]   supp_vec,
  output logic [NUM_CH-1:0]   event_o,
  output logic                any_o
);

  logic [NUM_CH-1:0] prev_q;
  logic              arm_q;
  logic              any_q;
  logic              live;

  assign live = det_en & arm_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    edge_lane lane_i (
      .cur  (din[g]),
      .prev (prev_q[g]),
      .code (code_vec[2*g +: 2]),
      .supp (supp_vec[g]),
      .live (live),
      .hit  (event_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      arm_q  <= 1'b0;
      any_q  <= 1'b0;
    end else begin
      if (det_en) prev_q <= din;
      arm_q <= det_en;
      any_q <= |event_o;
    end
  end

  assign any_o = any_q;

endmodule

// File: rtl/edge_scan_top.sv
module edge_scan_top #(
  parameter int NUM_CH = 256,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              det_en,
  input  logic [NUM_CH-1:0] din,
  output logic [NUM_CH-1:0] event_o,
  output logic              any_o
);

  logic [2*NUM_CH-1:0] code_vec;
  logic [NUM_CH-1:0]   supp_vec;
  logic [IDX_W-1:0]    sel_idx;
  logic [1:0]          sel_code;

  edge_cfg_regs #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .code_vec (code_vec),
    .supp_vec (supp_vec),
    .sel_idx  (sel_idx),
    .sel_code (sel_code)
  );

  edge_event_core #(.NUM_CH(NUM_CH)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_en   (det_en),
    .din      (din),
    .code_vec (code_vec),
    .supp_vec (supp_vec),
    .event_o  (event_o),
    .any_o    (any_o)
  );

endmodule

// File: rtl/edge_scan_chk.sv
module edge_scan_chk
  import edge_scan_pkg::*;
#(
  parameter int NUM_CH = 256,
  parameter int ADDR_W = 6,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        wr_code,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [NUM_CH-1:0] event_o,
  input logic              any_o,
  input logic [NUM_CH-1:0] supp_vec,
  input logic [IDX_W-1:0]  sel_idx,
  input logic [1:0]        sel_code
);

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == REG_SEL) |=> sel_idx == $past(wr_idx));

  // R4
  rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == REG_CODE && wr_code == 2'b11) |=> $stable(sel_code));

  // R8
  supp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o & supp_vec) == '0);

  // R9
  any_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_o) |=> any_o);

  // R9
  any_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> $past(|event_o));

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |-> event_o == '0);

  // R10
  first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_en) |-> event_o == '0);

endmodule

bind edge_scan_top edge_scan_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .det_en   (det_en),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_code  (wr_data[1:0]),
  .wr_idx   (wr_data[IDX_W-1:0]),
  .event_o  (event_o),
  .any_o    (any_o),
  .supp_vec (supp_vec),
  .sel_idx  (sel_idx),
  .sel_code (sel_code)
);

// File: tb/edge_scan_top_tb_top.sv
`timescale 1ns/1ps
module edge_scan_top_tb_top;

  localparam int N = 256;

  typedef struct {
    logic [N-1:0] ev;
    string        tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [5:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          det_en = 1'b0;
  logic [N-1:0]  din = '0;
  logic [N-1:0]  event_o;
  logic          any_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t q[$];

  // bench-side model
  logic [1:0]   m_code [N];
  logic         m_supp [N];
  logic [7:0]   m_sel;
  logic [N-1:0] m_prev;
  logic         m_armed;

  always #2.5 clk = ~clk;

  edge_scan_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .det_en(det_en), .din(din),
    .event_o(event_o), .any_o(any_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev  <= '0;
      m_armed <= 1'b0;
    end else begin
      if (det_en) m_prev <= din;
      m_armed <= det_en;
    end
  end

  function automatic logic [N-1:0] predict(input logic [N-1:0] cur, input logic en);
    logic [N-1:0] r;
    r = '0;
    for (int n = 0; n < N; n++) begin
      logic up, dn;
      up = cur[n] && !m_prev[n];
      dn = !cur[n] && m_prev[n];
      if (en && m_armed && !m_supp[n]) begin
        if (m_code[n] == 2'd0) r[n] = up;
        else if (m_code[n] == 2'd1) r[n] = dn;
        else if (m_code[n] == 2'd2) r[n] = up || dn;
      end
    end
    return r;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, expected item pushed to the scoreboard
  task automatic drive(input logic [N-1:0] v, input logic en, input string tag);
    exp_t it;
    @(negedge clk);
    det_en = en;
    din = v;
    it.ev = predict(v, en);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 6'(a);
    wr_data = d;
    if (a == 0) m_sel = d[7:0];
    else if (a == 1 && d[1:0] != 2'd3) m_code[m_sel] = d[1:0];
    else if (a == 2) m_supp[m_sel] = d[0];
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  function automatic logic [31:0] code_word(input int w);
    logic [31:0] r;
    for (int j = 0; j < 16; j++) r[2*j +: 2] = m_code[16*w + j];
    return r;
  endfunction

  function automatic logic [31:0] supp_word(input int w);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = m_supp[32*w + j];
    return r;
  endfunction

  task automatic readback_all(input string tc, input string ts);
    @(negedge clk);
    rd_addr = 6'd0;
    #1 check(rd_data, {24'd0, m_sel}, {tc, " selector"});
    for (int w = 0; w < 16; w++) begin
      rd_addr = 6'(16 + w);
      #1 check(rd_data, code_word(w), $sformatf("%s code word %0d", tc, w));
    end
    for (int w = 0; w < 8; w++) begin
      rd_addr = 6'(32 + w);
      #1 check(rd_data, supp_word(w), $sformatf("%s suppress word %0d", ts, w));
    end
  endtask

  // monitor: pops expected items and compares events and the any flag
  initial begin
    logic last_any;
    last_any = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() == 0) begin
        last_any = 1'b0;
      end else begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (event_o !== it.ev) begin
          errors++;
          $display("FAIL %s events actual=%h expected=%h", it.tag, event_o, it.ev);
        end
        checks++;
        if (any_o !== last_any) begin
          errors++;
          $display("FAIL R9 any_o actual=%b expected=%b (%s)", any_o, last_any, it.tag);
        end
        last_any = |it.ev;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      m_code[n] = 2'd0;
      m_supp[n] = 1'b0;
    end
    m_sel = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    readback_all("R1", "R1");

    // R10 first enabled cycle after reset: edges present but no event
    drive('1, 1'b1, "R10 first cycle after reset");
    // R5 all channels rising, then falling gives nothing
    drive('0, 1'b1, "R5 falling ignored by rising code");
    drive({N/32{32'hA5C3_0F96}}, 1'b1, "R5 rising pattern");
    drive('1, 1'b1, "R5 rising rest");

    // program all channels: rotating codes, sparse suppress, reserved attempts
    for (int n = 0; n < N; n++) begin
      reg_wr(0, 32'(n));
      reg_wr(1, 32'(n % 3));
      if (n % 7 == 0) reg_wr(2, 32'd1);
      if (n % 5 == 0) reg_wr(1, 32'hFFFF_FFF3);
    end
    reg_wr(0, 32'd200);
    readback_all("R2 R4", "R3");

    // R4 reserved write to selected channel 200 leaves its code
    reg_wr(1, 32'd3);
    @(negedge clk);
    rd_addr = 6'(16 + 200 / 16);
    #1 check(rd_data, code_word(200 / 16), "R4 reserved code on channel 200");
    // R3 clear one suppress bit then read back
    reg_wr(0, 32'd63);
    reg_wr(2, 32'd0);
    @(negedge clk);
    rd_addr = 6'(32 + 1);
    #1 check(rd_data, supp_word(1), "R3 suppress clear channel 63");

    // R6 R7 R8 directed full toggles
    drive('0, 1'b1, "R6 R7 R8 all fall");
    drive('1, 1'b1, "R5 R7 R8 all rise");
    drive('0, 1'b1, "R6 R7 R8 all fall again");
    // random traffic across mixed codes
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] v;
      for (int w = 0; w < N / 32; w++) v[32*w +: 32] = $urandom;
      drive(v, 1'b1, "R5 R6 R7 R8 random traffic");
    end
    // R10 disabled cycles with changing input, then re-enable
    for (int k = 0; k < 6; k++) drive(~din, 1'b0, "R10 disabled");
    drive(~din, 1'b1, "R10 first cycle after enable");
    drive(~din, 1'b1, "R7 after re-enable");
    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] v;
      for (int w = 0; w < N / 32; w++) v[32*w +: 32] = $urandom;
      drive(v, (k % 9) != 4, "R10 R9 enable toggling");
    end
    drive(din, 1'b1, "R9 quiet tail");
    drive(din, 1'b1, "R9 quiet tail");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule